// File: doc/BRIEF.md
# Weighted Fair Queueing Tag Scheduler

This block orders packet departures across several flows so that the link is shared as if every flow were served a fixed number of bits per round, in proportion to its weight. Each arriving packet is stamped with the virtual round in which it would finish under that bit-level service. The dequeue side always hands out the waiting packet with the smallest stamp. Only the stamps are stored: payload storage and the running round counter live outside, and the current round number is an input.

A packet arriving to an idle flow starts at the current round. A packet arriving behind earlier packets of the same flow starts where the previous one finished. Its finish stamp is the start plus its length scaled down by the flow's weight. Weights are powers of two, set as a shift amount per flow, so the scaling is a right shift. Each flow keeps its stamps in a small first-in first-out buffer. A packet offered to a full buffer is dropped and flagged.

Top module: `wfq_tag_sched`

## Requirements
- R1: After reset, `enqError` and `deqGrant` are low, every flow is empty, and every weight shift is 0 (weight 1).
- R2: A packet enqueued to a flow whose buffer is empty at that clock edge gets start stamp equal to `roundNow`.
- R3: A packet enqueued to a flow that already holds packets gets as start stamp the finish stamp of the most recently enqueued packet of that flow, regardless of `roundNow`.
- R4: The finish stamp is start + (`enqLen` >> shift), taken modulo 2^TAG_W. The shift of a flow is written by `cfgWrEn` with `cfgFlow` and `cfgShift`, and it gives weight 2^shift.
- R5: A cycle with `deqReq` high while any flow holds a packet removes the head packet with the smallest finish stamp. In the next cycle `deqGrant` is high for one cycle, with `deqFlow` and `deqTag` naming that packet.
- R6: When several head stamps are equal, the flow with the lowest index wins.
- R7: Packets of one flow leave in the order in which they were enqueued.
- R8: Each flow holds FIFO_DEPTH (8) stamps. An enqueue to a full flow stores nothing, and `enqError` is high for exactly the next cycle.
- R9: A `deqReq` while all flows are empty produces no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Packet arrival strobe |
| enqFlow | input | FLOW_W | Flow index of the arriving packet |
| enqLen | input | LEN_W | Packet length in bits |
| roundNow | input | TAG_W | Current virtual round number |
| cfgWrEn | input | 1 | Weight shift write strobe |
| cfgFlow | input | FLOW_W | Flow whose weight is written |
| cfgShift | input | SH_W | log2 of the flow weight |
| deqReq | input | 1 | Dequeue request |
| deqGrant | output | 1 | A packet was dequeued (one cycle after the request) |
| deqFlow | output | FLOW_W | Flow of the dequeued packet |
| deqTag | output | TAG_W | Finish stamp of the dequeued packet |
| enqError | output | 1 | Previous enqueue was rejected because its flow was full |

## Verification
A corrupted stored stamp or a wrong start choice shows up at `deqTag` on the very grant that removes the affected packet. A wrong fill count shows up either as a missing or an extra `enqError` on the ninth arrival, or as a grant that appears or is missing when a drained flow is requested once more. Selection faults change the `deqFlow` sequence at the first dequeue where two flows compete, so the bench replays a mixed two-round arrival pattern with known finish rounds. It also covers weighted and tied cases, and a fill-and-drain of one flow.

// File: rtl/wfq_pkg.sv
package wfq_pkg;
  // Strobes issued by the control to the datapath every cycle
  typedef struct packed {
    logic doPush;    // store the arriving stamp
    logic reject;    // arrival dropped, flow full
    logic doPop;     // remove the winning head
    logic grant;     // report the winner next cycle
  } ctrl_strobes_t;
endpackage

// File: rtl/wfq_tag_fifo.sv
module wfq_tag_fifo #(
  parameter int TAG_W = 24,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [TAG_W-1:0] din,
  output logic [TAG_W-1:0] headTag,
  output logic             notEmpty,
  output logic             isFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= din;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (pop) rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign headTag  = mem[rdPtr];
  assign notEmpty = (count != '0);
  assign isFull   = (int'(count) == DEPTH);

  // R8: the control never stores into a full buffer
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (int'(count) < DEPTH || pop));
  // R9: the control never removes from an empty buffer
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));
endmodule

// File: rtl/wfq_min_select.sv
module wfq_min_select #(
  parameter int NUM_FLOWS = 4,
  parameter int TAG_W     = 24,
  parameter int FLOW_W    = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_FLOWS-1:0]            validVec,
  input  logic [NUM_FLOWS-1:0][TAG_W-1:0] headTags,
  output logic                            anyValid,
  output logic [FLOW_W-1:0]               winIdx,
  output logic [TAG_W-1:0]                winTag
);
  // Linear scan, strict less-than keeps the lowest index on ties
  always_comb begin
    anyValid = 1'b0;
    winIdx   = '0;
    winTag   = '0;
    for (int i = 0; i < NUM_FLOWS; i++) begin
      if (validVec[i] && (!anyValid || headTags[i] < winTag)) begin
        anyValid = 1'b1;
        winIdx   = FLOW_W'(i);
        winTag   = headTags[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_chk
    // R5: no valid head is smaller than the chosen one
    p_min_tag_r5: assert property (@(posedge clk) disable iff (!rstN)
      validVec[g] |-> (headTags[winIdx] <= headTags[g]));
    // R6: every lower-index valid head is strictly larger
    p_tie_low_r6: assert property (@(posedge clk) disable iff (!rstN)
      (validVec[g] && g < int'(winIdx)) |-> (headTags[g] > headTags[winIdx]));
  end
endmodule

// File: rtl/wfq_ctrl.sv
module wfq_ctrl
  import wfq_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int FLOW_W    = 2
) (
  input  logic                 enqValid,
  input  logic [FLOW_W-1:0]    enqFlow,
  input  logic                 deqReq,
  input  logic [NUM_FLOWS-1:0] fullVec,
  input  logic                 anyValid,
  output ctrl_strobes_t        strb
);
  logic flowFull;

  assign flowFull = fullVec[enqFlow];

  always_comb begin
    strb.doPush = enqValid && !flowFull;
    strb.reject = enqValid && flowFull;
    strb.doPop  = deqReq && anyValid;
    strb.grant  = deqReq && anyValid;
  end
endmodule

// File: rtl/wfq_datapath.sv
module wfq_datapath
  import wfq_pkg::*;
#(
  parameter int NUM_FLOWS  = 4,
  parameter int TAG_W      = 24,
  parameter int LEN_W      = 16,
  parameter int SH_W       = 3,
  parameter int FIFO_DEPTH = 8,
  parameter int FLOW_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobes_t        strb,
  input  logic [FLOW_W-1:0]    enqFlow,
  input  logic [LEN_W-1:0]     enqLen,
  input  logic [TAG_W-1:0]     roundNow,
  input  logic                 cfgWrEn,
  input  logic [FLOW_W-1:0]    cfgFlow,
  input  logic [SH_W-1:0]      cfgShift,
  output logic [NUM_FLOWS-1:0] fullVec,
  output logic                 anyValid,
  output logic                 deqGrant,
  output logic [FLOW_W-1:0]    deqFlow,
  output logic [TAG_W-1:0]     deqTag,
  output logic                 enqError
);
  localparam int PAD_W = TAG_W - LEN_W;

  logic [SH_W-1:0]                 wShift  [NUM_FLOWS];
  logic [TAG_W-1:0]                lastTag [NUM_FLOWS];
  logic [NUM_FLOWS-1:0]            validVec;
  logic [NUM_FLOWS-1:0][TAG_W-1:0] headTags;
  logic [FLOW_W-1:0]               winIdx;
  logic [TAG_W-1:0]                winTag;
  logic [TAG_W-1:0]                startTag, scaledLen, finishTag;

  // Stamp computation for the arriving packet
  always_comb begin
    startTag  = validVec[enqFlow] ? lastTag[enqFlow] : roundNow;
    scaledLen = {{PAD_W{1'b0}}, enqLen >> wShift[enqFlow]};
    finishTag = startTag + scaledLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FLOWS; i++) begin
        wShift[i]  <= '0;
        lastTag[i] <= '0;
      end
      deqGrant <= 1'b0;
      deqFlow  <= '0;
      deqTag   <= '0;
      enqError <= 1'b0;
    end else begin
      if (cfgWrEn)     wShift[cfgFlow]  <= cfgShift;
      if (strb.doPush) lastTag[enqFlow] <= finishTag;
      deqGrant <= strb.grant;
      enqError <= strb.reject;
      if (strb.grant) begin
        deqFlow <= winIdx;
        deqTag  <= winTag;
      end
    end
  end

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_flow
    logic pushHere, popHere;
    assign pushHere = strb.doPush && (enqFlow == FLOW_W'(g));
    assign popHere  = strb.doPop  && (winIdx  == FLOW_W'(g));

    wfq_tag_fifo #(.TAG_W(TAG_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushHere),
      .pop      (popHere),
      .din      (finishTag),
      .headTag  (headTags[g]),
      .notEmpty (validVec[g]),
      .isFull   (fullVec[g])
    );
  end

  wfq_min_select #(.NUM_FLOWS(NUM_FLOWS), .TAG_W(TAG_W), .FLOW_W(FLOW_W)) i_min (
    .clk      (clk),
    .rstN     (rstN),
    .validVec (validVec),
    .headTags (headTags),
    .anyValid (anyValid),
    .winIdx   (winIdx),
    .winTag   (winTag)
  );

  // R8: an error pulse lasts one cycle unless another rejected arrival follows
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    enqError |-> $past(strb.reject));
endmodule

// File: rtl/wfq_tag_sched.sv
module wfq_tag_sched
  import wfq_pkg::*;
#(
  parameter int NUM_FLOWS  = 4,
  parameter int TAG_W      = 24,
  parameter int LEN_W      = 16,
  parameter int SH_W       = 3,
  parameter int FIFO_DEPTH = 8,
  localparam int FLOW_W    = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [FLOW_W-1:0] enqFlow,
  input  logic [LEN_W-1:0]  enqLen,
  input  logic [TAG_W-1:0]  roundNow,
  input  logic              cfgWrEn,
  input  logic [FLOW_W-1:0] cfgFlow,
  input  logic [SH_W-1:0]   cfgShift,
  input  logic              deqReq,
  output logic              deqGrant,
  output logic [FLOW_W-1:0] deqFlow,
  output logic [TAG_W-1:0]  deqTag,
  output logic              enqError
);
  ctrl_strobes_t        strb;
  logic [NUM_FLOWS-1:0] fullVec;
  logic                 anyValid;

  wfq_ctrl #(.NUM_FLOWS(NUM_FLOWS), .FLOW_W(FLOW_W)) i_ctrl (
    .enqValid (enqValid),
    .enqFlow  (enqFlow),
    .deqReq   (deqReq),
    .fullVec  (fullVec),
    .anyValid (anyValid),
    .strb     (strb)
  );

  wfq_datapath #(
    .NUM_FLOWS(NUM_FLOWS), .TAG_W(TAG_W), .LEN_W(LEN_W), .SH_W(SH_W),
    .FIFO_DEPTH(FIFO_DEPTH), .FLOW_W(FLOW_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .enqFlow  (enqFlow),
    .enqLen   (enqLen),
    .roundNow (roundNow),
    .cfgWrEn  (cfgWrEn),
    .cfgFlow  (cfgFlow),
    .cfgShift (cfgShift),
    .fullVec  (fullVec),
    .anyValid (anyValid),
    .deqGrant (deqGrant),
    .deqFlow  (deqFlow),
    .deqTag   (deqTag),
    .enqError (enqError)
  );

  // R5: a grant only follows a request
  p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    deqGrant |-> $past(deqReq));
  // R8: an error only follows an arrival
  p_err_needs_enq_r8: assert property (@(posedge clk) disable iff (!rstN)
    enqError |-> $past(enqValid));
endmodule

// File: tb/test_wfq_tag_sched.sv
module test_wfq_tag_sched;
  localparam int NF = 4;
  localparam int TW = 24;
  localparam int LW = 16;
  localparam int SW = 3;
  localparam int FW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enqValid = 1'b0;
  logic [FW-1:0] enqFlow = '0;
  logic [LW-1:0] enqLen = '0;
  logic [TW-1:0] roundNow = '0;
  logic          cfgWrEn = 1'b0;
  logic [FW-1:0] cfgFlow = '0;
  logic [SW-1:0] cfgShift = '0;
  logic          deqReq = 1'b0;
  logic          deqGrant, enqError;
  logic [FW-1:0] deqFlow;
  logic [TW-1:0] deqTag;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  wfq_tag_sched #(.NUM_FLOWS(NF), .TAG_W(TW), .LEN_W(LW), .SH_W(SW), .FIFO_DEPTH(8))
  i_wfq_tag_sched (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqFlow(enqFlow), .enqLen(enqLen),
    .roundNow(roundNow), .cfgWrEn(cfgWrEn), .cfgFlow(cfgFlow), .cfgShift(cfgShift),
    .deqReq(deqReq), .deqGrant(deqGrant), .deqFlow(deqFlow), .deqTag(deqTag),
    .enqError(enqError)
  );

  // Stimulus table: op 0 = enqueue (flow, len at round), op 1 = dequeue expecting (flow, tag)
  localparam int NV = 16;
  localparam int vOp   [NV] = '{0,0,0,0,0,0, 0,0, 1,1,1,1,1,1,1,1};
  localparam int vFlow [NV] = '{0,1,2,2,3,3, 0,2, 2,3,2,1,3,0,2,0};
  localparam int vLen  [NV] = '{4,3,1,1,1,2, 2,2, 0,0,0,0,0,0,0,0};
  localparam int vRnd  [NV] = '{0,0,0,0,0,0, 1,1, 0,0,0,0,0,0,0,0};
  localparam int vTag  [NV] = '{0,0,0,0,0,0, 0,0, 1,1,2,3,3,4,4,6};

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enq(input int f, input int len, input int rnd, input int expErr, input string req);
    @(negedge clk);
    enqValid = 1'b1; enqFlow = FW'(f); enqLen = LW'(len); roundNow = TW'(rnd);
    @(negedge clk);
    enqValid = 1'b0;
    chk(req, int'(enqError), expErr);
  endtask

  task automatic setShift(input int f, input int sh);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgFlow = FW'(f); cfgShift = SW'(sh);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic deq(input int expG, input int expF, input int expT, input string req);
    @(negedge clk);
    deqReq = 1'b1;
    @(negedge clk);
    deqReq = 1'b0;
    chk({req, " grant"}, int'(deqGrant), expG);
    if (expG != 0) begin
      chk({req, " flow"}, int'(deqFlow), expF);
      chk({req, " tag"}, int'(deqTag), expT);
    end
    @(negedge clk);
    chk({req, " grant single cycle"}, int'(deqGrant), 0);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1 deqGrant", int'(deqGrant), 0);
    chk("R1 enqError", int'(enqError), 0);
    // R9 / R1: nothing stored after reset, so no grant
    deq(0, 0, 0, "R9 empty request");

    // Two-round equal-weight pattern: R2, R3, R5, R6, R7
    for (int k = 0; k < NV; k++) begin
      if (vOp[k] == 0) enq(vFlow[k], vLen[k], vRnd[k], 0, "R3 enqueue accepted");
      else             deq(1, vFlow[k], vTag[k], "R5 R6 table order");
    end
    deq(0, 0, 0, "R9 drained");

    // Weighted: flow0 weight 4, flow1 weight 2, flow2 weight 1 (R4, R6)
    setShift(0, 2);
    setShift(1, 1);
    enq(0, 8, 10, 0, "R4 enq");
    enq(1, 8, 10, 0, "R4 enq");
    enq(2, 2, 10, 0, "R4 enq");
    deq(1, 0, 12, "R4 R6 weight4 tie");
    deq(1, 2, 12, "R6 tie second");
    deq(1, 1, 14, "R4 weight2");

    // Fill flow3 to depth: R2 start at round, R3 chaining, R8 rejection, R7 order
    for (int k = 0; k < 8; k++) enq(3, 1, 100 + 50 * k, 0, "R8 fill");
    enq(3, 1, 900, 1, "R8 full rejected");
    @(negedge clk);
    chk("R8 error one cycle", int'(enqError), 0);
    for (int k = 0; k < 8; k++) deq(1, 3, 101 + k, "R7 R3 fifo order");
    deq(0, 0, 0, "R8 rejected not stored");

    // R2: empty again, start from the round, not the old chain end
    enq(3, 5, 500, 0, "R2 enq");
    deq(1, 3, 505, "R2 restart at round");

    // R4: modulo wrap of the stamp
    enq(1, 4, 16777214, 0, "R4 enq");
    deq(1, 1, 0, "R4 wrap");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule